// File: doc/BRIEF.md
# PPM Clock Trim Calibrator

This block trims the average rate of a slow real-time clock by removing and adding individual pulses. Every cycle of `clk_i` is one raw pulse of the slow source. The block reports on `pulses_o` how many calibrated pulses the cycle is worth: 0 when the pulse is removed, 1 normally, and 2 when an extra pulse is added. The downstream prescaler chain adds this value to its count.

Pulses are counted over a calibration window of `2^WIN_LOG2` cycles. Two select inputs can shorten the window to a half or a quarter of that length. A 9-bit removal count sets how many pulses are dropped per full window. The dropped pulses are spread evenly through the window: the window is cut into 512 slots, and a slot's index is bit-reversed and compared with the removal count. An insertion enable adds one pulse per slot, which is 512 per full window. A full window therefore gains `512*ins - rem` pulses.

Settings are staged by a write strobe. They take effect together at the next window boundary, and a pending flag shows that a latch is still to come.

Top module: `ppm_clk_trim`

## Requirements
- R1: With both select inputs low, a window lasts `2^WIN_LOG2` cycles. The window counter restarts at every window boundary, and the first window starts at the first cycle after reset is released.
- R2: If `win_half_i` is high, the window lasts `2^(WIN_LOG2-1)` cycles. If `win_quarter_i` is high, it lasts `2^(WIN_LOG2-2)` cycles, and the quarter select wins when both are high.
- R3: In half mode, bit 0 of the removal count is forced to 0 when the settings are latched.
- R4: In quarter mode, bits 1:0 of the removal count are forced to 0 when the settings are latched.
- R5: Within one window the number of cycles with `pulses_o`=0 is the effective removal count divided by the window shortening factor (1, 2 or 4). In full mode it is exactly the removal count.
- R6: With the insertion enable latched high, a window contains `512/factor` cycles with `pulses_o`=2. Together with R5, the sum of `pulses_o` over a window is `len - rem_eff/factor + ins*512/factor`.
- R7: Removals are spread over the window. In full mode the first half of the window holds `ceil(rem/2)` of them.
- R8: Settings written during a window do not affect that window. They apply from the next boundary, and the inputs are ignored while `cfg_wr_i` is low.
- R9: `cfg_pend_o` rises in the cycle after a write and falls in the cycle after the next window boundary.
- R10: In reset, `cfg_pend_o` is 0 and `pulses_o` is 1. After reset the latched settings are removal 0, insertion off, full window.
- R11: `pulses_o` only takes the values 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Raw slow clock; each cycle is one source pulse |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Write strobe; stages the settings inputs |
| rem_cnt_i | input | 9 | Pulses to remove per full window |
| ins_en_i | input | 1 | Adds one pulse per slot when high |
| win_half_i | input | 1 | Selects the half-length window |
| win_quarter_i | input | 1 | Selects the quarter-length window (wins over half) |
| pulses_o | output | 2 | Calibrated pulses for this cycle (0, 1 or 2) |
| cfg_pend_o | output | 1 | Staged settings are waiting for a boundary |

## Verification
`pulses_o` is combinational from the window position and the latched settings, so its value for a cycle is valid in that same cycle. The bench samples it at the falling edge and accumulates it per window, and compares the totals at the end of each window. A write presented at a falling edge is captured by the next rising edge. `cfg_pend_o` is therefore checked one falling edge after the strobe, and checked clear at the first falling edge of the following window. The new settings are expected only from the window after the write. The scoreboard holds one item per window, so the window in progress during a write is still compared against the old settings.

// File: rtl/ptrim_pkg.sv
package ptrim_pkg;
  localparam int REM_W = 9;

  typedef enum logic [1:0] {
    WIN_FULL  = 2'd0,
    WIN_HALF  = 2'd1,
    WIN_QUART = 2'd2
  } win_mode_e;

  typedef struct packed {
    logic [REM_W-1:0] rem;
    logic             ins;
    win_mode_e        mode;
  } trim_cfg_t;

  localparam trim_cfg_t CFG_RST = '{rem: '0, ins: 1'b0, mode: WIN_FULL};

  function automatic win_mode_e pick_mode(input logic half, input logic quart);
    if (quart)     return WIN_QUART;
    else if (half) return WIN_HALF;
    else           return WIN_FULL;
  endfunction

  // low removal bits the window can not spread evenly are cleared
  function automatic trim_cfg_t apply_mask(input trim_cfg_t c);
    trim_cfg_t r;
    r = c;
    case (c.mode)
      WIN_HALF:  r.rem[0]   = 1'b0;
      WIN_QUART: r.rem[1:0] = 2'b00;
      default:   r.rem      = c.rem;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ptrim_win_ctr.sv
module ptrim_win_ctr
  import ptrim_pkg::*;
#(
  parameter int WIN_LOG2 = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  win_mode_e           mode_i,
  output logic [WIN_LOG2-1:0] pos_o,
  output logic                wrap_o
);
  logic [WIN_LOG2-1:0] pos_q, last;
  logic [1:0]          sh;

  always_comb begin
    case (mode_i)
      WIN_HALF:  sh = 2'd1;
      WIN_QUART: sh = 2'd2;
      default:   sh = 2'd0;
    endcase
    last = {WIN_LOG2{1'b1}} >> sh;
  end

  assign wrap_o = (pos_q == last);
  assign pos_o  = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (wrap_o) pos_q <= '0;
    else             pos_q <= pos_q + 1'b1;
  end

  a_r1_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (pos_o == '0));
  a_r2_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_o <= last);
endmodule

// File: rtl/ptrim_cfg.sv
module ptrim_cfg
  import ptrim_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REM_W-1:0] rem_i,
  input  logic             ins_i,
  input  logic             half_i,
  input  logic             quart_i,
  input  logic             wrap_i,
  output trim_cfg_t        act_o,
  output logic             pend_o
);
  trim_cfg_t stg_q, stg_d, act_q;
  logic      pend_q;

  always_comb begin
    stg_d = stg_q;
    if (wr_i) stg_d = '{rem: rem_i, ins: ins_i, mode: pick_mode(half_i, quart_i)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= CFG_RST;
      act_q  <= CFG_RST;
      pend_q <= 1'b0;
    end else begin
      stg_q <= stg_d;
      if (wrap_i) act_q <= apply_mask(stg_d);
      if (wrap_i)    pend_q <= 1'b0;
      else if (wr_i) pend_q <= 1'b1;
    end
  end

  assign act_o  = act_q;
  assign pend_o = pend_q;

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(act_o));
  a_r3_half_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o.mode == WIN_HALF) |-> (act_o.rem[0] == 1'b0));
  a_r4_quart_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o.mode == WIN_QUART) |-> (act_o.rem[1:0] == 2'b00));
  a_r9_pend_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wrap_i) |=> pend_o);
  a_r9_pend_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> !pend_o);
endmodule

// File: rtl/ptrim_pulse.sv
module ptrim_pulse
  import ptrim_pkg::*;
#(
  parameter int WIN_LOG2 = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [WIN_LOG2-1:0] pos_i,
  input  trim_cfg_t           act_i,
  output logic [1:0]          pulses_o
);
  localparam int SLOT_W = WIN_LOG2 - REM_W;

  logic [REM_W-1:0]  slot, slot_rev;
  logic [SLOT_W-1:0] sub;
  logic              drop, add;

  assign slot = pos_i[WIN_LOG2-1 -: REM_W];
  assign sub  = pos_i[SLOT_W-1:0];

  for (genvar b = 0; b < REM_W; b++) begin : g_rev
    assign slot_rev[b] = slot[REM_W-1-b];
  end

  // removal at slot start, insertion at slot end: never the same cycle
  assign drop = (sub == '0) && (slot_rev < act_i.rem);
  assign add  = (sub == '1) && act_i.ins;

  always_comb begin
    if (drop)     pulses_o = 2'd0;
    else if (add) pulses_o = 2'd2;
    else          pulses_o = 2'd1;
  end

  a_r11_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulses_o != 2'd3);
  a_r5_drop_needs_rem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulses_o == 2'd0) |-> (act_i.rem != '0));
  a_r6_add_needs_ins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulses_o == 2'd2) |-> act_i.ins);
endmodule

// File: rtl/ppm_clk_trim.sv
module ppm_clk_trim
  import ptrim_pkg::*;
#(
  parameter int WIN_LOG2 = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_wr_i,
  input  logic [8:0] rem_cnt_i,
  input  logic       ins_en_i,
  input  logic       win_half_i,
  input  logic       win_quarter_i,
  output logic [1:0] pulses_o,
  output logic       cfg_pend_o
);
  logic [WIN_LOG2-1:0] pos;
  logic                wrap;
  trim_cfg_t           act;

  ptrim_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .rem_i   (rem_cnt_i),
    .ins_i   (ins_en_i),
    .half_i  (win_half_i),
    .quart_i (win_quarter_i),
    .wrap_i  (wrap),
    .act_o   (act),
    .pend_o  (cfg_pend_o)
  );

  ptrim_win_ctr #(.WIN_LOG2(WIN_LOG2)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (act.mode),
    .pos_o  (pos),
    .wrap_o (wrap)
  );

  ptrim_pulse #(.WIN_LOG2(WIN_LOG2)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pos_i    (pos),
    .act_i    (act),
    .pulses_o (pulses_o)
  );
endmodule

// File: tb/ppm_clk_trim_tb.sv
`timescale 1ns/1ps
module ppm_clk_trim_tb;
  localparam int WL  = 12;
  localparam int LEN = 1 << WL;

  typedef struct {
    int len;
    int total;
    int hz;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [8:0] rem = '0;
  logic       ins = 1'b0, half = 1'b0, quart = 1'b0;
  logic [1:0] pulses;
  logic       pend;

  int total = 0, bad = 0;
  bit done = 0;
  item_t q[$];

  always #2.5 clk = ~clk;

  ppm_clk_trim #(.WIN_LOG2(WL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .rem_cnt_i(rem),
    .ins_en_i(ins), .win_half_i(half), .win_quarter_i(quart),
    .pulses_o(pulses), .cfg_pend_o(pend)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic item_t mk(input int r, input int i, input int h, input int qt);
    item_t it;
    int s, re;
    s  = qt ? 2 : (h ? 1 : 0);
    re = r & ~((1 << s) - 1);
    it.len   = LEN >> s;
    it.total = it.len - (re >> s) + (i ? (512 >> s) : 0);
    it.hz    = (s == 0) ? (re + 1) / 2 : -1;
    return it;
  endfunction

  // driver: stage settings in the current window, expect them from the next
  task automatic apply(input int r, input int i, input int h, input int qt, input int n);
    wait (q.size() == 1);
    @(negedge clk);
    chk(pend == 1'b0, "R9 pend clear after boundary", pend, 0);
    rem = r[8:0]; ins = i[0]; half = h[0]; quart = qt[0]; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    rem = 9'h1a5; ins = ~ins; half = 1'b0; quart = 1'b0;  // R8 ignored without strobe
    chk(pend == 1'b1, "R9 pend after write", pend, 1);
    for (int k = 0; k < n; k++) q.push_back(mk(r, i, h, qt));
  endtask

  // monitor: per-window totals against the scoreboard
  initial begin
    int n = 0, acc = 0, z = 0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        acc += pulses;
        if (n < q[0].len / 2 && pulses == 2'd0) z++;
        n++;
        if (n == q[0].len) begin
          chk(acc == q[0].total, "R1 R2 R5 R6 R8 window total", acc, q[0].total);
          if (q[0].hz >= 0) chk(z == q[0].hz, "R7 first-half removals", z, q[0].hz);
          void'(q.pop_front());
          n = 0; acc = 0; z = 0;
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(pend == 1'b0, "R10 reset pend", pend, 0);
    chk(pulses == 2'd1, "R10 R11 reset pulses", pulses, 1);
    @(posedge clk);
    #1 rst_n = 1'b1;
    q.push_back(mk(0, 0, 0, 0));        // R10 reset settings
    apply(100, 0, 0, 0, 2);             // R5 R7 full window
    apply(511, 1, 0, 0, 1);             // R6 max removal with insertion
    apply(37,  1, 1, 0, 2);             // R3 half window, odd count
    apply(203, 0, 0, 1, 2);             // R4 quarter window
    apply(7,   1, 1, 1, 1);             // R2 R4 quarter wins over half
    apply(0,   1, 0, 0, 1);             // R6 insertion only
    apply(1,   0, 0, 0, 1);             // R7 single removal
    apply(300, 0, 0, 0, 1);
    wait (q.size() == 0);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule